// File: doc/BRIEF.md
# Multicycle Register-Transfer Datapath

This block holds the storage and arithmetic of a 32-bit processor that spends several clock cycles on each instruction. It covers register-to-register ALU operations, word load, word store, branch-if-equal and an absolute jump. Every control line is a plain input driven by an external sequencer. The datapath only moves values between its latched registers, a single ALU, a 32-entry register file and one shared memory port.

Instructions and data use the same memory port. The port has no back-pressure. The memory returns `mem_rdata` combinationally for the address on `mem_addr` within the same cycle. A store happens in any cycle where `mem_wr_en` is high. Because that protocol is fixed, the port carries no valid/ready pair.

The ALU is reused in different cycles. It adds 4 to the program counter during fetch. During decode it always precomputes a branch target. In later cycles it forms load/store addresses, R-type results and the equality test for branches. The results are held in latched registers between cycles. The program counter is observed at `mem_addr` whenever the address select picks the PC.

Top module: `mc_datapath`

## Requirements
- R1: After reset the program counter and every latched register read zero, so the first fetch presents address 0 on `mem_addr`.
- R2: With `ir_we` high the instruction register loads `mem_rdata`. With `pc_we` high, `pc_src`=00, `srca_sel`=0, `srcb_sel`=01 and `alu_ctl`=00, the PC becomes PC+4. With neither PC enable high, the PC holds.
- R3: Every cycle, operand register A loads register[instr 25:21] and B loads register[instr 20:16]. With `srca_sel`=0 and `srcb_sel`=11, the result register captures PC + (sign-extended instr 15:0 shifted left by 2).
- R4: `srcb_sel`=10 adds the sign-extended instr 15:0 to A. `mem_addr` shows the result register when `addr_sel`=1 and the PC when `addr_sel`=0.
- R5: The memory data register loads `mem_rdata` every cycle. With `rf_we`=1, `dst_sel`=0 and `wb_sel`=1, it is written to register[instr 20:16].
- R6: `mem_wdata` always carries B. `mem_rd_en` and `mem_wr_en` follow `mem_rd` and `mem_wr`.
- R7: With `alu_ctl`=10 the ALU decodes funct (instr 5:0): 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-less-than. With `dst_sel`=1 and `wb_sel`=0, the result is written to register[instr 15:11].
- R8: `alu_ctl`=00 selects add and `alu_ctl`=01 selects subtract, whatever the funct bits hold.
- R9: With `pc_we_cond` high and `pc_src`=01, the PC loads the result register only when the ALU output is zero. Otherwise it holds.
- R10: With `pc_we` high and `pc_src`=10, the PC becomes {PC[31:28], instr[25:0], 2'b00}.
- R11: Register 0 reads as zero and ignores writes.
- R12: `opcode` presents instruction register bits 31:26.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_we | input | 1 | Unconditional PC write |
| pc_we_cond | input | 1 | PC write when ALU result is zero |
| pc_src | input | 2 | PC source: 00 ALU, 01 result register, 10 jump |
| addr_sel | input | 1 | Memory address: 0 PC, 1 result register |
| mem_rd | input | 1 | Memory read request |
| mem_wr | input | 1 | Memory write request |
| ir_we | input | 1 | Instruction register load |
| wb_sel | input | 1 | Write-back data: 0 result register, 1 memory data register |
| dst_sel | input | 1 | Destination: 0 instr 20:16, 1 instr 15:11 |
| rf_we | input | 1 | Register file write |
| srca_sel | input | 1 | ALU input A: 0 PC, 1 operand A |
| srcb_sel | input | 2 | ALU input B: 00 B, 01 four, 10 immediate, 11 immediate<<2 |
| alu_ctl | input | 2 | 00 add, 01 subtract, 10 funct decode |
| mem_rdata | input | 32 | Memory read data (combinational) |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rd_en | output | 1 | Memory read enable |
| mem_wr_en | output | 1 | Memory write enable |
| opcode | output | 6 | Current instruction opcode |

## Verification
Combinational outputs (`mem_addr`, `mem_wdata`, `opcode`, the enables) are valid in the same cycle the controls are applied. The bench drives controls on the falling edge and samples 1 ns later. A register updated at a rising edge is seen in the next cycle's sample. The PC after a fetch, branch or jump is read at the following fetch. A load or R-type result is written back one edge after the ALU or memory cycle. It is checked by a later store, whose `mem_addr` and `mem_wdata` are sampled in the store cycle, and whose memory word is checked one edge later.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int XLEN = 32;

  typedef enum logic [2:0] {
    FN_ADD_E,
    FN_SUB_E,
    FN_AND_E,
    FN_OR_E,
    FN_SLT_E
  } alu_fn_e;

  localparam logic [1:0] AC_ADD   = 2'b00;
  localparam logic [1:0] AC_SUB   = 2'b01;
  localparam logic [1:0] AC_FUNCT = 2'b10;

  localparam logic [5:0] FC_ADD = 6'h20;
  localparam logic [5:0] FC_SUB = 6'h22;
  localparam logic [5:0] FC_AND = 6'h24;
  localparam logic [5:0] FC_OR  = 6'h25;
  localparam logic [5:0] FC_SLT = 6'h2A;

  localparam logic [1:0] SB_REG   = 2'b00;
  localparam logic [1:0] SB_FOUR  = 2'b01;
  localparam logic [1:0] SB_IMM   = 2'b10;
  localparam logic [1:0] SB_IMMSH = 2'b11;

  localparam logic [1:0] PS_ALU  = 2'b00;
  localparam logic [1:0] PS_HELD = 2'b01;
  localparam logic [1:0] PS_JUMP = 2'b10;

  function automatic alu_fn_e alu_decode(input logic [1:0] ctl, input logic [5:0] funct);
    alu_fn_e f;
    f = FN_ADD_E;
    case (ctl)
      AC_ADD: f = FN_ADD_E;
      AC_SUB: f = FN_SUB_E;
      AC_FUNCT: begin
        case (funct)
          FC_ADD:  f = FN_ADD_E;
          FC_SUB:  f = FN_SUB_E;
          FC_AND:  f = FN_AND_E;
          FC_OR:   f = FN_OR_E;
          FC_SLT:  f = FN_SLT_E;
          default: f = FN_ADD_E;
        endcase
      end
      default: f = FN_ADD_E;
    endcase
    return f;
  endfunction
endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W         = 32,
  parameter int AW        = 5,
  parameter bit HARD_ZERO = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2
);
  localparam int NREGS = 1 << AW;

  logic [W-1:0] regs [NREGS];
  logic         wr_ok;

  always_comb begin
    wr_ok = we;
    if (HARD_ZERO && (wa == '0)) wr_ok = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wr_ok) begin
      regs[wa] <= wd;
    end
  end

  generate
    if (HARD_ZERO) begin : g_zero
      assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
      assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
    end else begin : g_plain
      assign rd1 = regs[ra1];
      assign rd2 = regs[ra2];
    end
  endgenerate
endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int W  = 32,
  parameter int FW = 6
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [1:0]    ctl,
  input  logic [FW-1:0] funct,
  output logic [W-1:0]  y,
  output logic          zero
);
  alu_fn_e fn;

  always_comb begin
    fn = alu_decode(ctl, funct);
    unique case (fn)
      FN_ADD_E: y = a + b;
      FN_SUB_E: y = a - b;
      FN_AND_E: y = a & b;
      FN_OR_E:  y = a | b;
      FN_SLT_E: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default:  y = a + b;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/mc_immgen.sv
module mc_immgen #(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input  logic [IW-1:0] imm,
  output logic [W-1:0]  sext,
  output logic [W-1:0]  sext_sh2
);
  localparam int EXT = W - IW;

  assign sext     = {{EXT{imm[IW-1]}}, imm};
  assign sext_sh2 = {sext[W-3:0], 2'b00};
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
#(
  parameter int RAW = 5,
  parameter int IMW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pc_we,
  input  logic            pc_we_cond,
  input  logic [1:0]      pc_src,
  input  logic            addr_sel,
  input  logic            mem_rd,
  input  logic            mem_wr,
  input  logic            ir_we,
  input  logic            wb_sel,
  input  logic            dst_sel,
  input  logic            rf_we,
  input  logic            srca_sel,
  input  logic [1:0]      srcb_sel,
  input  logic [1:0]      alu_ctl,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic            mem_rd_en,
  output logic            mem_wr_en,
  output logic [5:0]      opcode
);
  localparam int JW     = XLEN - 6;
  localparam int RS_LSB = 21;
  localparam int RT_LSB = 16;
  localparam int RD_LSB = 11;

  logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, aluout_q, mdr_q;
  logic [XLEN-1:0] rf_rd1, rf_rd2, rf_wd;
  logic [RAW-1:0]  rf_wa;
  logic [XLEN-1:0] imm_s, imm_s2;
  logic [XLEN-1:0] alu_a, alu_b, alu_y, pc_next, jump_tgt;
  logic            alu_zero, pc_load;

  mc_regfile #(.W(XLEN), .AW(RAW), .HARD_ZERO(1'b1)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra1(ir_q[RS_LSB +: RAW]), .ra2(ir_q[RT_LSB +: RAW]),
    .we(rf_we), .wa(rf_wa), .wd(rf_wd),
    .rd1(rf_rd1), .rd2(rf_rd2)
  );

  mc_immgen #(.W(XLEN), .IW(IMW)) u_imm (
    .imm(ir_q[IMW-1:0]), .sext(imm_s), .sext_sh2(imm_s2)
  );

  mc_alu #(.W(XLEN), .FW(6)) u_alu (
    .a(alu_a), .b(alu_b), .ctl(alu_ctl), .funct(ir_q[5:0]),
    .y(alu_y), .zero(alu_zero)
  );

  always_comb begin
    alu_a = srca_sel ? a_q : pc_q;
    unique case (srcb_sel)
      SB_REG:   alu_b = b_q;
      SB_FOUR:  alu_b = XLEN'(4);
      SB_IMM:   alu_b = imm_s;
      SB_IMMSH: alu_b = imm_s2;
      default:  alu_b = b_q;
    endcase
  end

  assign jump_tgt = {pc_q[XLEN-1:XLEN-4], ir_q[JW-1:0], 2'b00};

  always_comb begin
    case (pc_src)
      PS_ALU:  pc_next = alu_y;
      PS_HELD: pc_next = aluout_q;
      PS_JUMP: pc_next = jump_tgt;
      default: pc_next = alu_y;
    endcase
  end

  assign pc_load = pc_we | (pc_we_cond & alu_zero);
  assign rf_wa   = dst_sel ? ir_q[RD_LSB +: RAW] : ir_q[RT_LSB +: RAW];
  assign rf_wd   = wb_sel ? mdr_q : aluout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= '0;
      ir_q     <= '0;
      a_q      <= '0;
      b_q      <= '0;
      aluout_q <= '0;
      mdr_q    <= '0;
    end else begin
      if (pc_load) pc_q <= pc_next;
      if (ir_we)   ir_q <= mem_rdata;
      a_q      <= rf_rd1;
      b_q      <= rf_rd2;
      aluout_q <= alu_y;
      mdr_q    <= mem_rdata;
    end
  end

  assign mem_addr  = addr_sel ? aluout_q : pc_q;
  assign mem_wdata = b_q;
  assign mem_rd_en = mem_rd;
  assign mem_wr_en = mem_wr;
  assign opcode    = ir_q[XLEN-1:XLEN-6];
endmodule

// File: rtl/mc_datapath_chk.sv
module mc_datapath_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] pc,
  input logic [31:0] ir,
  input logic [31:0] a,
  input logic [31:0] aluout,
  input logic        zero,
  input logic        pc_we,
  input logic        pc_we_cond,
  input logic [1:0]  pc_src,
  input logic        srca_sel,
  input logic [1:0]  srcb_sel,
  input logic [1:0]  alu_ctl,
  input logic        ir_we
);
  // R2
  pc_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we && pc_src == 2'b00 && !srca_sel && srcb_sel == 2'b01 && alu_ctl == 2'b00)
    |=> pc == $past(pc) + 32'd4);

  // R2
  pc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_we && !pc_we_cond) |=> $stable(pc));

  // R2
  ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_we |=> $stable(ir));

  // R9
  beq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we_cond && !pc_we && !zero) |=> $stable(pc));

  // R9
  beq_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we_cond && !pc_we && zero && pc_src == 2'b01) |=> pc == $past(aluout));

  // R10
  jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we && pc_src == 2'b10) |=> pc == {$past(pc[31:28]), $past(ir[25:0]), 2'b00});

  // R11
  zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ir[25:21] == 5'd0) |=> a == 32'd0);
endmodule

bind mc_datapath mc_datapath_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pc(pc_q), .ir(ir_q), .a(a_q), .aluout(aluout_q),
  .zero(alu_zero), .pc_we(pc_we), .pc_we_cond(pc_we_cond), .pc_src(pc_src),
  .srca_sel(srca_sel), .srcb_sel(srcb_sel), .alu_ctl(alu_ctl), .ir_we(ir_we)
);

// File: tb/test_mc_datapath.sv
`timescale 1ns/1ps
module test_mc_datapath;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pc_we, pc_we_cond, addr_sel, mem_rd, mem_wr, ir_we, wb_sel, dst_sel, rf_we, srca_sel;
  logic [1:0]  pc_src, srcb_sel, alu_ctl;
  logic [31:0] mem_rdata, mem_addr, mem_wdata;
  logic        mem_rd_en, mem_wr_en;
  logic [5:0]  opcode;

  logic [31:0] mem [64];
  logic [31:0] exp_pc;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  mc_datapath i_mc_datapath (.*);

  assign mem_rdata = mem[mem_addr[7:2]];
  always @(posedge clk) if (mem_wr_en) mem[mem_addr[7:2]] <= mem_wdata;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    pc_we = 0; pc_we_cond = 0; pc_src = 2'b00; addr_sel = 0; mem_rd = 0; mem_wr = 0;
    ir_we = 0; wb_sel = 0; dst_sel = 0; rf_we = 0; srca_sel = 0; srcb_sel = 2'b00; alu_ctl = 2'b00;
  endtask

  function automatic logic [31:0] enc_r(input int rd, input int rs, input int rt, input logic [5:0] f);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, f};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction

  // fetch + decode; checks PC on mem_addr (R2) and opcode (R12)
  task automatic fetch_decode(input logic [31:0] instr, input string pc_req);
    mem[exp_pc[7:2]] = instr;
    idle(); mem_rd = 1; ir_we = 1; pc_we = 1; srcb_sel = 2'b01;
    #1 chk(pc_req, mem_addr, exp_pc);
    chk("R6 rd_en", {31'd0, mem_rd_en}, 32'd1);
    @(negedge clk);
    exp_pc = exp_pc + 4;
    idle(); srcb_sel = 2'b11;
    #1 chk("R12", {26'd0, opcode}, {26'd0, instr[31:26]});
    @(negedge clk);
  endtask

  task automatic t_lw(input int rt, input int base, input logic [15:0] off, input logic [31:0] ea);
    fetch_decode(enc_i(6'h23, base, rt, off), "R2");
    idle(); srca_sel = 1; srcb_sel = 2'b10; @(negedge clk);
    idle(); addr_sel = 1; mem_rd = 1;
    #1 chk("R4 load address", mem_addr, ea);
    @(negedge clk);
    idle(); rf_we = 1; wb_sel = 1; dst_sel = 0; @(negedge clk);
    idle();
  endtask

  task automatic t_sw(input int rt, input int base, input logic [15:0] off,
                      input logic [31:0] ea, input logic [31:0] data, input string req);
    fetch_decode(enc_i(6'h2B, base, rt, off), "R2");
    idle(); srca_sel = 1; srcb_sel = 2'b10; @(negedge clk);
    idle(); addr_sel = 1; mem_wr = 1;
    #1 chk("R4 store address", mem_addr, ea);
    chk(req, mem_wdata, data);
    chk("R6 wr_en", {31'd0, mem_wr_en}, 32'd1);
    @(negedge clk);
    idle();
    #1 chk("R6 stored word", mem[ea[7:2]], data);
  endtask

  task automatic t_rtype(input int rd, input int rs, input int rt, input logic [5:0] f);
    fetch_decode(enc_r(rd, rs, rt, f), "R2");
    idle(); srca_sel = 1; srcb_sel = 2'b00; alu_ctl = 2'b10; @(negedge clk);
    idle(); rf_we = 1; dst_sel = 1; wb_sel = 0; @(negedge clk);
    idle();
  endtask

  task automatic t_beq(input int rs, input int rt, input logic [15:0] off, input bit taken);
    logic [31:0] tgt;
    fetch_decode(enc_i(6'h04, rs, rt, off), "R2");
    tgt = exp_pc + {{14{off[15]}}, off, 2'b00};
    idle(); srca_sel = 1; srcb_sel = 2'b00; alu_ctl = 2'b01; pc_we_cond = 1; pc_src = 2'b01;
    @(negedge clk);
    idle();
    if (taken) exp_pc = tgt;
  endtask

  task automatic t_j(input logic [25:0] idx);
    fetch_decode({6'h02, idx}, "R2");
    idle(); pc_we = 1; pc_src = 2'b10; @(negedge clk);
    idle();
    exp_pc = {exp_pc[31:28], idx, 2'b00};
  endtask

  // peek PC through next fetch address without executing
  task automatic pc_probe(input string req);
    idle();
    #1 chk(req, mem_addr, exp_pc);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'd0;
    idle();
    exp_pc = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    #1 chk("R1 pc", mem_addr, 32'd0);
    chk("R1 wr_en", {31'd0, mem_wr_en}, 32'd0);
    chk("R1 opcode", {26'd0, opcode}, 32'd0);
    @(negedge clk);

    mem[48] = 32'd7;
    mem[49] = 32'hFFFF_FFFD;
    mem[50] = 32'h0F0F_00F0;
    mem[51] = 32'h00FF_0FF0;

    // R5 loads, R8 add on address
    t_lw(1, 0, 16'h00C0, 32'h0000_00C0);
    t_lw(2, 0, 16'h00C4, 32'h0000_00C4);
    t_lw(9, 0, 16'h00C8, 32'h0000_00C8);
    t_lw(10, 0, 16'h00CC, 32'h0000_00CC);
    t_sw(1, 0, 16'h00D0, 32'h0000_00D0, 32'd7, "R5 loaded value");

    // R7 funct decode
    t_rtype(3, 1, 2, 6'h20);
    t_sw(3, 0, 16'h00D4, 32'h0000_00D4, 32'd4, "R7 add");
    t_rtype(4, 1, 2, 6'h22);
    t_sw(4, 0, 16'h00D8, 32'h0000_00D8, 32'd10, "R7 sub");
    t_rtype(5, 9, 10, 6'h24);
    t_sw(5, 0, 16'h00DC, 32'h0000_00DC, 32'h000F_00F0, "R7 and");
    t_rtype(6, 9, 10, 6'h25);
    t_sw(6, 0, 16'h00E0, 32'h0000_00E0, 32'h0FFF_0FF0, "R7 or");
    t_rtype(7, 2, 1, 6'h2A);
    t_sw(7, 0, 16'h00E4, 32'h0000_00E4, 32'd1, "R7 slt true");
    t_rtype(7, 1, 2, 6'h2A);
    t_sw(7, 0, 16'h00E8, 32'h0000_00E8, 32'd0, "R7 slt false");

    // R11: write to register 0 ignored
    t_rtype(0, 1, 1, 6'h20);
    t_sw(0, 0, 16'h00EC, 32'h0000_00EC, 32'd0, "R11 reg0");

    // R4: negative offset, base r3 = 4 -> 0xFFFFFFFC
    t_sw(1, 3, 16'hFFF8, 32'hFFFF_FFFC, 32'd7, "R4 negative offset data");

    // R9 not taken (7 != -3), R8 subtract
    t_beq(1, 2, 16'd3, 1'b0);
    pc_probe("R9 not taken");
    // R9 taken forward, R3 target precompute
    t_beq(4, 4, 16'd2, 1'b1);
    pc_probe("R9 taken forward");
    // R10 jump
    t_j(26'd8);
    pc_probe("R10 jump");
    // R9/R3 taken backward
    t_beq(0, 0, 16'hFFFE, 1'b1);
    pc_probe("R3 backward target");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule